// File: doc/BRIEF.md
# Cross-Domain Mailbox Register

This block carries one data word from a writing port to a reading port that runs on an unrelated clock, outside the FIFO that links the same two ports. The writer stores a word by making an enabled write transfer with its mailbox select high. The reader sees an active-low mail flag go low once the word is safe to take. It collects the word with an enabled read transfer whose mailbox select is high, and that read raises the flag again. The flag is also raised by the reset of the FIFO that runs in the same direction.

While a word is pending, the mailbox refuses new writes. The writer side has a ready output (`a_ready`), which acts as the back-pressure signal. A mailbox write with `a_ready` low is dropped, not held: it changes neither the stored word nor the flag, and the writer must repeat it once `a_ready` is high again. `a_ready` returns high on the third writer edge after the read that emptied the mailbox.

On the reader side the data output is a multiplexer. A high mailbox select shows the stored word. A low mailbox select shows the FIFO output register, which arrives on `b_fifo_q`. The store and the take each cross between the clock domains as a toggle through a chain of synchronizer flops (two by default).

Top module: `xdom_mailbox`

## Requirements
- R1: A writer edge stores `a_din` into the mailbox when all of these hold: `a_sel_n` is low, `a_en` is high, `a_write` is high, `a_mb` is high and `a_ready` is high. `a_ready` is low from the next writer edge on.
- R2: After a store, `b_mail_full_n` goes low on the third reader edge that follows the storing writer edge, with two synchronizer stages.
- R3: While `a_ready` is low, mailbox writes are ignored: the word later shown on `b_dout` is the first one stored, and the flag does not change.
- R4: A reader edge with `b_sel_n` low, `b_en` high, `b_read` high, `b_mb` high and `b_mail_full_n` low drives `b_mail_full_n` high. `a_ready` then returns high on the third writer edge after that reader edge.
- R5: While `rst_n` is low, and right after it rises, `b_mail_full_n` is high, `a_ready` is high and the stored word is zero.
- R6: `b_dout` shows the stored word when `b_mb` is high and shows `b_fifo_q` when `b_mb` is low, on the same cycle.
- R7: A transfer stores or takes only if select is low, enable is high and the direction pin picks the matching direction. Any other combination leaves both the mailbox and the flag as they were.
- R8: If a store arrives at the reader on the same reader edge as a mailbox read, the new word is kept and `b_mail_full_n` goes low.
- R9: A mailbox read while `b_mail_full_n` is high has no effect: no early release of `a_ready`, and no later loss of a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Reset of the same-direction FIFO, active low, asynchronous |
| a_clk | input | 1 | Writer clock |
| a_sel_n | input | 1 | Writer port select, active low |
| a_en | input | 1 | Writer transfer enable |
| a_write | input | 1 | Writer direction, 1 = write |
| a_mb | input | 1 | Writer mailbox select |
| a_din | input | 36 | Writer data |
| a_ready | output | 1 | Mailbox can accept a word (writer domain) |
| b_clk | input | 1 | Reader clock |
| b_sel_n | input | 1 | Reader port select, active low |
| b_en | input | 1 | Reader transfer enable |
| b_read | input | 1 | Reader direction, 1 = read |
| b_mb | input | 1 | Reader mailbox select for the output mux |
| b_fifo_q | input | 36 | FIFO output register data |
| b_dout | output | 36 | Reader data output |
| b_mail_full_n | output | 1 | Mail pending flag, active low (reader domain) |

## Verification
Suppose the writer's pending state is lost: `a_ready` rises early, and the next mailbox read returns a word that overwrote the unread one. If the reader misses an arrival, the flag never falls, and this shows three reader cycles after the store. If the take toggle is lost, `a_ready` stays low for good. Each of these errors appears at the ports within three clocks of its own domain, so a reference compared on every edge of both clocks points to the cycle where it began.

// File: rtl/xdom_mailbox_pkg.sv
package xdom_mailbox_pkg;

  // Control pins of one port, sampled at that port's clock edge.
  typedef struct packed {
    logic sel_n;
    logic en;
    logic dir;   // 1 = the transfer direction this side performs
    logic mb;
  } port_ctl_t;

  // True for an enabled mailbox transfer in the side's own direction.
  function automatic logic mbox_hit(input port_ctl_t c);
    return !c.sel_n && c.en && c.dir && c.mb;
  endfunction

endpackage

// File: rtl/xdom_bit_sync.sv
module xdom_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xdom_mbox_wr.sv
module xdom_mbox_wr
  import xdom_mailbox_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_ctl_t         ctl,
  input  logic [DATA_W-1:0] din,
  input  logic              take_tog_s,   // synchronized take toggle
  output logic              ready,
  output logic              put_tog,
  output logic [DATA_W-1:0] word
);
  logic busy;
  logic take_seen;
  logic fire, store, ack;

  assign fire  = mbox_hit(ctl);
  assign store = fire && !busy;
  assign ack   = take_tog_s != take_seen;
  assign ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      take_seen <= 1'b0;
      put_tog   <= 1'b0;
      word      <= '0;
    end else begin
      if (ack) begin
        take_seen <= take_tog_s;
        busy      <= 1'b0;
      end
      if (store) begin
        word    <= din;
        put_tog <= ~put_tog;
        busy    <= 1'b1;
      end
    end
  end

  // R1
  store_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (!ready && word == $past(din)));

  // R3
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ready) |=> $stable(word) && $stable(put_tog));

  // R4
  ack_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ready);
endmodule

// File: rtl/xdom_mbox_rd.sv
module xdom_mbox_rd
  import xdom_mailbox_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_ctl_t         ctl,
  input  logic              put_tog_s,    // synchronized put toggle
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] dout,
  output logic              full_n,
  output logic              take_tog
);
  logic full;
  logic put_seen;
  logic fire, take, arrive;

  assign fire   = mbox_hit(ctl);
  assign take   = fire && full;
  assign arrive = put_tog_s != put_seen;
  assign full_n = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      put_seen <= 1'b0;
      take_tog <= 1'b0;
    end else begin
      if (take) begin
        full     <= 1'b0;
        take_tog <= ~take_tog;
      end
      if (arrive) begin
        put_seen <= put_tog_s;
        full     <= 1'b1;
      end
    end
  end

  // Output mux: mailbox word or FIFO output register.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mux
      assign dout[i] = ctl.mb ? word[i] : fifo_q[i];
    end
  endgenerate

  // R3
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arrive |-> !full);

  // R8
  arrive_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arrive |=> full);

  // R4
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !arrive) |=> !full && (take_tog != $past(take_tog)));

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !full) |=> $stable(take_tog));
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
  import xdom_mailbox_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_sel_n,
  input  logic              a_en,
  input  logic              a_write,
  input  logic              a_mb,
  input  logic [DATA_W-1:0] a_din,
  output logic              a_ready,
  input  logic              b_clk,
  input  logic              b_sel_n,
  input  logic              b_en,
  input  logic              b_read,
  input  logic              b_mb,
  input  logic [DATA_W-1:0] b_fifo_q,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_mail_full_n
);
  port_ctl_t         a_ctl, b_ctl;
  logic              put_tog, put_tog_s;
  logic              take_tog, take_tog_s;
  logic [DATA_W-1:0] word;

  assign a_ctl = '{sel_n: a_sel_n, en: a_en, dir: a_write, mb: a_mb};
  assign b_ctl = '{sel_n: b_sel_n, en: b_en, dir: b_read,  mb: b_mb};

  xdom_mbox_wr #(.DATA_W(DATA_W)) u_wr (
    .clk(a_clk), .rst_n(rst_n), .ctl(a_ctl), .din(a_din),
    .take_tog_s(take_tog_s), .ready(a_ready), .put_tog(put_tog), .word(word)
  );

  xdom_bit_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
    .clk(b_clk), .rst_n(rst_n), .d(put_tog), .q(put_tog_s)
  );

  xdom_bit_sync #(.STAGES(SYNC_STAGES)) u_take_sync (
    .clk(a_clk), .rst_n(rst_n), .d(take_tog), .q(take_tog_s)
  );

  xdom_mbox_rd #(.DATA_W(DATA_W)) u_rd (
    .clk(b_clk), .rst_n(rst_n), .ctl(b_ctl), .put_tog_s(put_tog_s),
    .word(word), .fifo_q(b_fifo_q), .dout(b_dout), .full_n(b_mail_full_n),
    .take_tog(take_tog)
  );

  // R5
  reset_idle_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    $rose(rst_n) |-> b_mail_full_n);
endmodule

// File: tb/xdom_mailbox_test.sv
`timescale 1ns/1ps
module xdom_mailbox_test;
  localparam int W = 36;

  logic rst_n = 1'b0;
  logic a_clk = 1'b0, b_clk = 1'b0;
  logic a_sel_n = 1'b1, a_en = 1'b0, a_write = 1'b0, a_mb = 1'b0;
  logic [W-1:0] a_din = '0;
  logic a_ready;
  logic b_sel_n = 1'b1, b_en = 1'b0, b_read = 1'b0, b_mb = 1'b0;
  logic [W-1:0] b_fifo_q = '0;
  logic [W-1:0] b_dout;
  logic b_mail_full_n;

  // 100 MHz on both ports, reader edges 3 ns after writer edges.
  always #5 a_clk = ~a_clk;
  initial begin #3; forever #5 b_clk = ~b_clk; end

  xdom_mailbox uut (
    .rst_n(rst_n), .a_clk(a_clk), .a_sel_n(a_sel_n), .a_en(a_en),
    .a_write(a_write), .a_mb(a_mb), .a_din(a_din), .a_ready(a_ready),
    .b_clk(b_clk), .b_sel_n(b_sel_n), .b_en(b_en), .b_read(b_read),
    .b_mb(b_mb), .b_fifo_q(b_fifo_q), .b_dout(b_dout),
    .b_mail_full_n(b_mail_full_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int phase = 0;

  // Reference model: pending counters in edges of the far clock.
  bit m_busy = 0, m_full = 0;
  int wpend = 0, rpend = 0;
  logic [W-1:0] m_word = '0;

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge rst_n) begin
    m_busy = 0; m_full = 0; wpend = 0; rpend = 0; m_word = '0;
  end

  always @(posedge a_clk) if (rst_n) begin
    if (!a_sel_n && a_en && a_write && a_mb && !m_busy) begin
      m_word = a_din; m_busy = 1; wpend = 3;
    end
    if (rpend > 0) begin
      rpend--;
      if (rpend == 0) m_busy = 0;
    end
  end

  always @(posedge b_clk) if (rst_n) begin
    bit arrive;
    arrive = 0;
    if (wpend > 0) begin
      wpend--;
      arrive = (wpend == 0);
    end
    if (!b_sel_n && b_en && b_read && b_mb && m_full) begin
      m_full = 0; rpend = 3;
    end
    if (arrive) m_full = 1;
  end

  // Writer side: check, then drive new inputs.
  initial begin
    logic [63:0] r;
    while (!done) begin
      @(negedge a_clk);
      cmp("R1 R3 R4 R9 a_ready", {{(W-1){1'b0}}, a_ready}, {{(W-1){1'b0}}, !m_busy});
      r = {$urandom, $urandom};
      a_sel_n = ($urandom % 8) == 0;
      a_en    = ($urandom % 6) != 0;
      a_write = ($urandom % 5) != 0;
      a_mb    = (phase == 1) ? 1'b1 : (($urandom % 3) != 0);
      a_din   = r[W-1:0];
    end
  end

  // Reader side: check, then drive new inputs.
  initial begin
    logic [63:0] r;
    while (!done) begin
      @(negedge b_clk);
      cmp("R2 R4 R7 R8 R9 flag", {{(W-1){1'b0}}, b_mail_full_n}, {{(W-1){1'b0}}, !m_full});
      cmp("R6 dout", b_dout, b_mb ? m_word : b_fifo_q);
      r = {$urandom, $urandom};
      b_sel_n  = ($urandom % 8) == 0;
      b_en     = ($urandom % 6) != 0;
      b_read   = ($urandom % 5) != 0;
      b_mb     = (phase == 1) ? (($urandom % 12) == 0) : (($urandom % 2) != 0);
      b_fifo_q = r[W-1:0];
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (!done) begin
      @(posedge a_clk);
      wd++;
      if (wd > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
      end
    end
  end

  initial begin
    #26;                       // away from both edges
    // R5: reset state at the ports
    cmp("R5 flag", {{(W-1){1'b0}}, b_mail_full_n}, {{(W-1){1'b0}}, 1'b1});
    cmp("R5 ready", {{(W-1){1'b0}}, a_ready}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b1;
    repeat (3000) @(posedge a_clk);
    phase = 1;                 // slow reader: many blocked writes (R3)
    repeat (3000) @(posedge a_clk);
    @(negedge a_clk); #1;
    rst_n = 1'b0;              // reset in mid traffic (R5)
    repeat (3) @(posedge a_clk);
    @(negedge a_clk); #1;
    cmp("R5 flag", {{(W-1){1'b0}}, b_mail_full_n}, {{(W-1){1'b0}}, 1'b1});
    cmp("R5 ready", {{(W-1){1'b0}}, a_ready}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b1;
    phase = 0;
    repeat (3000) @(posedge a_clk);
    done = 1;
    @(negedge b_clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule